// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup and Replacement Unit

This block is the tag-and-data store of a small cache, with two ways per set. A request carries a block address, a read/write flag and write data. The unit picks a set from the low bits of the block address and compares the stored tags of both ways against the upper bits at the same time. In the same cycle it reports a hit, which way hit, and that way's data. A write hit updates the stored word in place.

On a miss the unit records the request, chooses a victim way and lowers `reqReady`. It then asks the next level for the block through a one-beat fill handshake. When the fill arrives, the new tag, valid bit and data go into the victim way, and the unit becomes ready again. A write miss allocates the block and stores the request's write data in place of the filled word. The caller repeats a read after a miss to get the filled data.

Each set keeps one least-recently-used bit. Any hit or fill on a way marks the other way as least recently used. The victim is an invalid way if one exists, and otherwise the least recently used way.

Top module: `cache2w`

## Requirements
- R1: After reset every entry is invalid, so the first access to any block misses. `reqReady` is 1 and `fillReq` is 0 after reset.
- R2: The set index is the block address modulo `SETS`, which is its low `log2(SETS)` bits. The tag is the remaining upper bits. Blocks whose low bits differ never evict each other.
- R3: For an accepted request (`reqValid` and `reqReady` both 1), `respHit` is valid combinationally in the same cycle. `respHit` is 1 only for an accepted request. On a read hit, `respRdata` holds the stored word of the hitting way.
- R4: In the cycle after an accepted miss, `fillReq` is 1 and `fillAddr` equals the missed address. Both hold until the cycle in which `fillValid` is 1. While `fillReq` is 1, `reqReady` is 0 and presented requests are ignored: they give no hit and change no state. In the cycle after the fill beat, `reqReady` is 1 and `fillReq` is 0.
- R5: On a miss, if the set has an invalid way, the new block goes there. Way 0 is used before way 1. `respHitWay` reports the way index, 0 or 1.
- R6: On a miss when both ways of the set are valid, the new block replaces the way that was least recently hit or filled.
- R7: Every hit and every fill makes the touched way the most recently used of its set.
- R8: A write hit replaces the stored word of the hitting way. A write miss installs the write data and not the fill data.
- R9: With 2 sets and the block sequence 0, 8, 0, 6, 8, the outcomes are miss, miss, hit, miss, miss. At the end, set 0 holds blocks 8 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | BLK_ADDR_W | Block address of the request |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Unit accepts a request this cycle |
| respHit | output | 1 | Accepted request hit |
| respHitWay | output | 1 | Way that hit |
| respRdata | output | DATA_W | Data of the hitting way |
| fillReq | output | 1 | Block fetch outstanding |
| fillAddr | output | BLK_ADDR_W | Block address to fetch |
| fillValid | input | 1 | Fill beat present |
| fillData | input | DATA_W | Returned block |

## Verification
The bench targets the point where both ways are valid and the recency order decides the victim. A design with the LRU bit inverted, or one that skips the update on hits, installs into the wrong way. A later access then reports the wrong `respHitWay`, or misses where it should hit.

The bench also targets the order in which invalid ways are preferred. Taking way 1 first, or using the LRU bit while a way is still empty, shows up as a wrong way index on the very first pair of fills.

While a fill is outstanding, the bench presents requests with varied delays. A unit that accepted them, or that dropped `fillReq` early, would disagree with the model's ready state or corrupt a set.

Write misses check that the write data, and not the fill word, is what gets installed.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  localparam int unsigned NUM_WAYS = 2;

  typedef struct packed {
    logic capture;      // latch a missing request and its victim
    logic hitUpdate;    // touch the hitting way (and write it)
    logic fillInstall;  // write the returned block into the victim
  } ctrlStrobe_t;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_FILL = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/cache2w_datapath.sv
module cache2w_datapath
  import cache2w_pkg::*;
#(
  parameter int unsigned BLK_ADDR_W = 10,
  parameter int unsigned SETS       = 16,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  reqWrite,
  input  logic [BLK_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     fillData,
  output logic                  hit,
  output logic                  hitWay,
  output logic [DATA_W-1:0]     rdata,
  output logic [BLK_ADDR_W-1:0] pendAddr
);

  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = BLK_ADDR_W - SET_W;

  // storage
  logic [TAG_W-1:0]  tagQ   [NUM_WAYS][SETS];
  logic [DATA_W-1:0] dataQ  [NUM_WAYS][SETS];
  logic              validQ [NUM_WAYS][SETS];
  logic              lruQ   [SETS];            // index of least recently used way

  // request decode
  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  assign setIdx = reqAddr[SET_W-1:0];
  assign reqTag = reqAddr[BLK_ADDR_W-1:SET_W];

  // parallel compare, one comparator per way
  logic [NUM_WAYS-1:0] wayHit;
  logic [NUM_WAYS-1:0] wayValid;
  logic [DATA_W-1:0]   wayData [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign wayValid[w] = validQ[w][setIdx];
    assign wayHit[w]   = wayValid[w] && (tagQ[w][setIdx] == reqTag);
    assign wayData[w]  = dataQ[w][setIdx];
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];
  assign rdata  = wayData[hitWay];

  // victim: empty way first (lowest index), else least recently used
  logic victimWay;
  always_comb begin
    if (!wayValid[0])      victimWay = 1'b0;
    else if (!wayValid[1]) victimWay = 1'b1;
    else                   victimWay = lruQ[setIdx];
  end

  // pending miss record
  logic              pendWrite;
  logic [DATA_W-1:0] pendWdata;
  logic              pendVictim;
  logic [SET_W-1:0]  pendSet;
  logic [TAG_W-1:0]  pendTag;

  assign pendSet = pendAddr[SET_W-1:0];
  assign pendTag = pendAddr[BLK_ADDR_W-1:SET_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr   <= '0;
      pendWrite  <= 1'b0;
      pendWdata  <= '0;
      pendVictim <= 1'b0;
    end else if (strobe.capture) begin
      pendAddr   <= reqAddr;
      pendWrite  <= reqWrite;
      pendWdata  <= reqWdata;
      pendVictim <= victimWay;
    end
  end

  // valid and recency state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lruQ[s] <= 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) validQ[w][s] <= 1'b0;
      end
    end else if (strobe.hitUpdate) begin
      lruQ[setIdx] <= ~hitWay;
    end else if (strobe.fillInstall) begin
      validQ[pendVictim][pendSet] <= 1'b1;
      lruQ[pendSet]               <= ~pendVictim;
    end
  end

  // tag and data arrays
  always_ff @(posedge clk) begin
    if (strobe.hitUpdate && reqWrite) begin
      dataQ[hitWay][setIdx] <= reqWdata;
    end else if (strobe.fillInstall) begin
      tagQ[pendVictim][pendSet]  <= pendTag;
      dataQ[pendVictim][pendSet] <= pendWrite ? pendWdata : fillData;
    end
  end

endmodule

// File: rtl/cache2w_control.sv
module cache2w_control
  import cache2w_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        fillValid,
  output logic        reqReady,
  output logic        accept,
  output logic        fillReq,
  output ctrlStrobe_t strobe
);

  ctrlState_t stateQ, stateD;

  assign reqReady = (stateQ == CTRL_IDLE);
  assign fillReq  = (stateQ == CTRL_FILL);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe             = '0;
    strobe.hitUpdate   = accept && hit;
    strobe.capture     = accept && !hit;
    strobe.fillInstall = fillReq && fillValid;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      CTRL_IDLE: if (strobe.capture)     stateD = CTRL_FILL;
      CTRL_FILL: if (strobe.fillInstall) stateD = CTRL_IDLE;
      default:                           stateD = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= CTRL_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int unsigned BLK_ADDR_W = 10,
  parameter int unsigned SETS       = 16,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [BLK_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  reqReady,
  output logic                  respHit,
  output logic                  respHitWay,
  output logic [DATA_W-1:0]     respRdata,
  output logic                  fillReq,
  output logic [BLK_ADDR_W-1:0] fillAddr,
  input  logic                  fillValid,
  input  logic [DATA_W-1:0]     fillData
);

  ctrlStrobe_t strobe;
  logic        lookupHit;
  logic        accept;

  cache2w_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .hit       (lookupHit),
    .fillValid (fillValid),
    .reqReady  (reqReady),
    .accept    (accept),
    .fillReq   (fillReq),
    .strobe    (strobe)
  );

  cache2w_datapath #(
    .BLK_ADDR_W (BLK_ADDR_W),
    .SETS       (SETS),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .fillData (fillData),
    .hit      (lookupHit),
    .hitWay   (respHitWay),
    .rdata    (respRdata),
    .pendAddr (fillAddr)
  );

  assign respHit = accept && lookupHit;

endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker #(
  parameter int unsigned BLK_ADDR_W = 10,
  parameter int unsigned DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [BLK_ADDR_W-1:0] reqAddr,
  input logic                  reqReady,
  input logic                  respHit,
  input logic                  fillReq,
  input logic [BLK_ADDR_W-1:0] fillAddr,
  input logic                  fillValid,
  input logic [DATA_W-1:0]     fillData
);

  assert_no_hit_unaccepted_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |-> !respHit);

  assert_miss_starts_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !respHit) |=> (fillReq && fillAddr == $past(reqAddr)));

  assert_fill_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillValid) |=> (fillReq && $stable(fillAddr)));

  assert_stall_while_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !reqReady);

  assert_fill_releases_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillValid) |=> (reqReady && !fillReq));

  assert_fill_data_known_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillValid) |-> !$isunknown(fillData));

endmodule

bind cache2w cache2w_checker #(
  .BLK_ADDR_W (BLK_ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqReady  (reqReady),
  .respHit   (respHit),
  .fillReq   (fillReq),
  .fillAddr  (fillAddr),
  .fillValid (fillValid),
  .fillData  (fillData)
);

// File: tb/cache2w_tb.sv
`timescale 1ns/1ps
module cache2w_tb;

  localparam int AW   = 6;
  localparam int NSET = 2;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqWrite;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic          reqReady, respHit, respHitWay;
  logic [DW-1:0] respRdata;
  logic          fillReq;
  logic [AW-1:0] fillAddr;
  logic          fillValid;
  logic [DW-1:0] fillData;

  always #5 clk = ~clk;

  cache2w #(.BLK_ADDR_W(AW), .SETS(NSET), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .respHit(respHit), .respHitWay(respHitWay), .respRdata(respRdata),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid),
    .fillData(fillData)
  );

  int checks   = 0;
  int failures = 0;

  // behavioural model: per set, two slots with a last-use timestamp
  bit            mVal  [NSET][2];
  int            mBlk  [NSET][2];
  logic [DW-1:0] mData [NSET][2];
  int            mLast [NSET][2];
  int            stamp = 0;
  bit            modelBusy = 1'b0;
  bit            monitorOn = 1'b0;
  bit            lastHit;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int a);
    return DW'(16'hA500 ^ (a * 16'h0101));
  endfunction

  // every-clock comparison of handshake state against the model
  always @(negedge clk) begin
    #1;
    if (monitorOn) begin
      chk(reqReady == !modelBusy, "R4", "reqReady vs model", reqReady, !modelBusy);
      chk(fillReq == modelBusy, "R4", "fillReq vs model", fillReq, modelBusy);
    end
  end

  task automatic access(input int addr, input bit wr, input logic [DW-1:0] wd,
                        input int fillDelay);
    int s;
    int hw;
    int v;
    s  = addr % NSET;
    hw = -1;
    for (int w = 0; w < 2; w++)
      if (mVal[s][w] && mBlk[s][w] == addr) hw = w;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(addr); reqWdata = wd;
    #2;
    chk(respHit == (hw >= 0), "R3", "respHit", respHit, hw >= 0);
    lastHit = respHit;
    if (hw >= 0) begin
      chk(respHitWay == hw[0], "R5/R6/R7", "respHitWay", respHitWay, hw);
      if (!wr) chk(respRdata == mData[s][hw], "R3/R8", "respRdata", respRdata, mData[s][hw]);
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
    stamp++;
    if (hw >= 0) begin
      mLast[s][hw] = stamp;
      if (wr) mData[s][hw] = wd;
      return;
    end
    if (!mVal[s][0])      v = 0;
    else if (!mVal[s][1]) v = 1;
    else                  v = (mLast[s][0] < mLast[s][1]) ? 0 : 1;
    modelBusy = 1'b1;
    chk(fillReq == 1'b1, "R4", "fillReq after miss", fillReq, 1);
    chk(fillAddr == AW'(addr), "R4", "fillAddr", fillAddr, addr);
    for (int d = 0; d < fillDelay; d++) begin
      @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(addr ^ 1); reqWdata = '1;
      #2;
      chk(respHit == 1'b0, "R4", "no hit while filling", respHit, 0);
      @(posedge clk); #1;
      reqValid = 1'b0;
      chk(fillAddr == AW'(addr), "R4", "fillAddr held", fillAddr, addr);
    end
    @(negedge clk);
    fillValid = 1'b1; fillData = pattern(addr);
    @(posedge clk); #1;
    fillValid = 1'b0;
    modelBusy = 1'b0;
    chk(reqReady == 1'b1 && fillReq == 1'b0, "R4", "released after fill",
        {reqReady, fillReq}, 2);
    mVal[s][v]  = 1'b1;
    mBlk[s][v]  = addr;
    mData[s][v] = wr ? wd : pattern(addr);
    mLast[s][v] = stamp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit exp9 [5];
    int seq9 [5];
    logic [7:0] lfsr;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    reqWdata = '0; fillValid = 1'b0; fillData = '0;
    for (int s = 0; s < NSET; s++)
      for (int w = 0; w < 2; w++) begin
        mVal[s][w] = 1'b0; mBlk[s][w] = -1; mData[s][w] = '0; mLast[s][w] = 0;
      end
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(fillReq == 1'b0, "R1", "fillReq after reset", fillReq, 0);
    monitorOn = 1'b1;

    // R9: classic sequence, all blocks in set 0
    seq9 = '{0, 8, 0, 6, 8};
    exp9 = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    for (int i = 0; i < 5; i++) begin
      access(seq9[i], 1'b0, '0, i);
      chk(lastHit == exp9[i], "R9", "sequence outcome", lastHit, exp9[i]);
    end
    access(8, 1'b0, '0, 0);
    chk(lastHit == 1'b1, "R9", "block 8 resident", lastHit, 1);
    access(6, 1'b0, '0, 0);
    chk(lastHit == 1'b1, "R9", "block 6 resident", lastHit, 1);

    // R1/R2: compulsory miss in set 1 leaves set 0 untouched
    access(1, 1'b0, '0, 1);
    chk(lastHit == 1'b0, "R1", "first access to block 1", lastHit, 0);
    access(8, 1'b0, '0, 0);
    chk(lastHit == 1'b1, "R2", "set 0 unaffected by set 1", lastHit, 1);

    // R8: write hit and write miss
    access(8, 1'b1, 16'h1234, 0);
    access(8, 1'b0, '0, 0);
    chk(respRdata == 16'h1234, "R8", "write hit data", respRdata, 16'h1234);
    access(33, 1'b1, 16'hBEEF, 2);
    access(33, 1'b0, '0, 0);
    chk(lastHit == 1'b1 && respRdata == 16'hBEEF, "R8", "write miss allocates",
        respRdata, 16'hBEEF);

    // R6/R7: touch block 1, then a new block evicts 33
    access(1, 1'b0, '0, 0);
    access(17, 1'b0, '0, 1);
    access(1, 1'b0, '0, 0);
    chk(lastHit == 1'b1, "R7", "recently hit block kept", lastHit, 1);
    access(33, 1'b0, '0, 0);
    chk(lastHit == 1'b0, "R6", "least recent block evicted", lastHit, 0);

    // mixed traffic against the model
    lfsr = 8'hA7;
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      access(int'(lfsr[3:0]), lfsr[6], {lfsr, ~lfsr}, int'(lfsr[5:4]));
    end

    monitorOn = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule